// File: doc/BRIEF.md
# Motor command pulse-frame receiver

This block takes one sampled line that carries 16-bit motor-control frames and turns each frame into decoded fields. Every bit sits in a bit slot of fixed length. The time the line spends at its active level, set against the length of that slot, decides whether the bit is 0 or 1. Bits are gathered most significant first. When the line stays quiet long enough, the block closes the frame. It then splits out the value, the telemetry-request flag and the checksum, checks the checksum, and marks the value as either a command or a throttle setting.

Two inputs set the mode. A two-bit rate code picks the nominal bit rate, and from it the block derives the slot length in clock cycles from the `CLK_HZ` parameter. A mode input selects bidirectional operation. In that mode the line idles high, each bit is a low pulse, and the expected checksum is inverted.

Decoded frames leave on a valid/ready stream with a single holding slot. While a frame waits unconsumed (`out_valid_o` high, `out_ready_i` low), the fields stay frozen, and any frame that completes in the meantime is discarded. The slot clears on the cycle after a handshake.

Top module: `pfr_rx`

## Requirements
- R1: Rate code `rate_i` selects the nominal bit period P = CLK_HZ / (150000 << rate_i) clock cycles (code 0 = 150, 1 = 300, 2 = 600, 3 = 1200 kbit/s).
- R2: A bit whose active time H and measured slot length T (active start to next active start) satisfy 2*H > T decodes as 1, otherwise as 0.
- R3: With `bidir_i` = 0 a bit starts on a rising edge and the active level is high. With `bidir_i` = 1 the line idles high, a bit starts on a falling edge and the active level is low.
- R4: Bits are taken most significant first. Frame bits 15..5 form `cmd_value_o`, bit 4 forms `telem_req_o`, and bits 3..0 are the received checksum.
- R5: With `bidir_i` = 0 the expected checksum is (d ^ d>>4 ^ d>>8) & 4'hF, where d is frame bits 15..4. Any mismatch sets `crc_err_o`.
- R6: With `bidir_i` = 1 the expected checksum is the bitwise inverse of the R5 value.
- R7: The frame closes when no new bit starts within 3*P cycles after the last active phase ends. The last bit is decoded against P. `out_valid_o` rises 3*P+3 clock edges after the edge that samples the end of the last active phase.
- R8: `is_command_o` is 1 exactly when `cmd_value_o` < 48.
- R9: A frame of any bit count other than 16 produces no output.
- R10: A checksum mismatch still presents the frame with `out_valid_o`, with `crc_err_o` = 1 and the decoded fields.
- R11: While `out_valid_o` = 1 and `out_ready_i` = 0, the outputs hold stable and a newly completed frame is dropped. After a handshake, `out_valid_o` falls on the next cycle.
- R12: During and directly after reset, `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled frame line |
| rate_i | input | 2 | Bit-rate select code |
| bidir_i | input | 1 | Bidirectional mode: inverted line and checksum |
| out_valid_o | output | 1 | Decoded frame available |
| out_ready_i | input | 1 | Consumer accepts the frame |
| cmd_value_o | output | 11 | Decoded 11-bit value |
| telem_req_o | output | 1 | Telemetry-request flag |
| crc_err_o | output | 1 | Received checksum does not match |
| is_command_o | output | 1 | Value is below 48 |

## Verification
The hardest case to reach from the ports is a frame that finishes while the previous one is still held under back-pressure. The bench stalls `out_ready_i`, sends a second complete frame, and only then releases the stall, so it can prove the second frame never appears. The close-of-frame timing depends on the active length of the last bit. To cover it, the sweep spans values, telemetry flags, both polarities and all four rates, so the last checksum bit takes both values and the exact latency is checked for each. Short, long and corrupted frames are sent at the fastest rate to keep the run brief.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int unsigned BASE_RATE_HZ = 150000;
  localparam int unsigned FRAME_BITS   = 16;
  localparam int unsigned VALUE_W      = 11;
  localparam int unsigned CMD_LIMIT    = 48;

  typedef struct packed {
    logic [VALUE_W-1:0] value;
    logic               telem;
    logic [3:0]         crc;
  } frame_t;

  function automatic int unsigned rate_hz(input logic [1:0] code);
    return BASE_RATE_HZ << code;
  endfunction

  function automatic logic [3:0] frame_crc(input logic [11:0] d, input logic inv);
    logic [11:0] x;
    x = d ^ (d >> 4) ^ (d >> 8);
    return inv ? ~x[3:0] : x[3:0];
  endfunction
endpackage

// File: rtl/pfr_timebase.sv
module pfr_timebase #(
  parameter int unsigned CLK_HZ = 48000000,
  parameter int unsigned CW     = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rate_i,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] silence_o
);
  logic [CW-1:0] tbl [4];
  logic [1:0]    rate_q;
  logic          loaded_q;

  for (genvar g = 0; g < 4; g++) begin : g_rate
    assign tbl[g] = CW'(CLK_HZ / pfr_pkg::rate_hz(2'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q    <= '0;
      loaded_q  <= 1'b0;
      period_o  <= '0;
      silence_o <= '0;
    end else if (!loaded_q || rate_i != rate_q) begin
      rate_q    <= rate_i;
      loaded_q  <= 1'b1;
      period_o  <= tbl[rate_i];
      silence_o <= CW'(3 * tbl[rate_i]);
    end
  end
endmodule

// File: rtl/pfr_bit_slicer.sv
module pfr_bit_slicer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] silence_i,
  output logic          bit_stb_o,
  output logic          bit_val_o,
  output logic          end_stb_o
);
  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_GAP} slice_e;

  localparam logic [CW-1:0] CNT_MAX = '1;

  slice_e        st_q;
  logic          act_q;
  logic [CW-1:0] cnt_q, hi_q, gap_q;
  logic          rise, fall;

  assign rise = act_i & ~act_q;
  assign fall = ~act_i & act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      act_q     <= 1'b0;
      cnt_q     <= '0;
      hi_q      <= '0;
      gap_q     <= '0;
      bit_stb_o <= 1'b0;
      bit_val_o <= 1'b0;
      end_stb_o <= 1'b0;
    end else begin
      act_q     <= act_i;
      bit_stb_o <= 1'b0;
      end_stb_o <= 1'b0;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      case (st_q)
        S_IDLE: begin
          if (rise) begin
            cnt_q <= CW'(1);
            st_q  <= S_ACTIVE;
          end
        end
        S_ACTIVE: begin
          if (fall) begin
            hi_q  <= cnt_q;
            gap_q <= CW'(1);
            st_q  <= S_GAP;
          end
        end
        default: begin
          if (gap_q != CNT_MAX) gap_q <= gap_q + 1'b1;
          if (rise) begin
            bit_stb_o <= 1'b1;
            bit_val_o <= {hi_q, 1'b0} > {1'b0, cnt_q};
            cnt_q     <= CW'(1);
            st_q      <= S_ACTIVE;
          end else if (gap_q >= silence_i) begin
            bit_stb_o <= 1'b1;
            end_stb_o <= 1'b1;
            bit_val_o <= {hi_q, 1'b0} > {1'b0, period_i};
            st_q      <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pfr_frame_asm.sv
module pfr_frame_asm
  import pfr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_stb_i,
  input  logic               bit_val_i,
  input  logic               end_stb_i,
  input  logic               bidir_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic [VALUE_W-1:0] value_o,
  output logic               telem_o,
  output logic               crc_err_o,
  output logic               is_cmd_o
);
  localparam int unsigned NW = $clog2(FRAME_BITS + 2);
  localparam logic [NW-1:0] N_SAT  = NW'(FRAME_BITS + 1);
  localparam logic [NW-1:0] N_LAST = NW'(FRAME_BITS - 1);

  logic [FRAME_BITS-2:0] sh_q;
  logic [NW-1:0]         nbits_q;
  frame_t                word;
  logic                  slot_free;

  assign word      = {sh_q, bit_val_i};
  assign slot_free = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      nbits_q     <= '0;
      out_valid_o <= 1'b0;
      value_o     <= '0;
      telem_o     <= 1'b0;
      crc_err_o   <= 1'b0;
      is_cmd_o    <= 1'b0;
    end else begin
      if (out_valid_o && out_ready_i) out_valid_o <= 1'b0;
      if (bit_stb_i) begin
        sh_q <= word[FRAME_BITS-2:0];
        if (nbits_q != N_SAT) nbits_q <= nbits_q + 1'b1;
      end
      if (end_stb_i) begin
        nbits_q <= '0;
        if (nbits_q == N_LAST && slot_free) begin
          out_valid_o <= 1'b1;
          value_o     <= word.value;
          telem_o     <= word.telem;
          crc_err_o   <= word.crc != frame_crc({word.value, word.telem}, bidir_i);
          is_cmd_o    <= word.value < VALUE_W'(CMD_LIMIT);
        end
      end
    end
  end
endmodule

// File: rtl/pfr_rx.sv
module pfr_rx #(
  parameter int unsigned CLK_HZ = 48000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_i,
  input  logic [1:0]  rate_i,
  input  logic        bidir_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [10:0] cmd_value_o,
  output logic        telem_req_o,
  output logic        crc_err_o,
  output logic        is_command_o
);
  localparam int unsigned MAX_PERIOD = CLK_HZ / pfr_pkg::BASE_RATE_HZ;
  localparam int unsigned CW         = $clog2(3 * MAX_PERIOD + 2);

  logic          line_q;
  logic          act;
  logic [CW-1:0] period, silence;
  logic          bit_stb, bit_val, end_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_i;
  end

  assign act = line_q ^ bidir_i;

  pfr_timebase #(.CLK_HZ(CLK_HZ), .CW(CW)) u_timebase (
    .clk_i, .rst_ni, .rate_i,
    .period_o (period),
    .silence_o(silence)
  );

  pfr_bit_slicer #(.CW(CW)) u_slicer (
    .clk_i, .rst_ni,
    .act_i    (act),
    .period_i (period),
    .silence_i(silence),
    .bit_stb_o(bit_stb),
    .bit_val_o(bit_val),
    .end_stb_o(end_stb)
  );

  pfr_frame_asm u_asm (
    .clk_i, .rst_ni,
    .bit_stb_i  (bit_stb),
    .bit_val_i  (bit_val),
    .end_stb_i  (end_stb),
    .bidir_i,
    .out_ready_i,
    .out_valid_o,
    .value_o    (cmd_value_o),
    .telem_o    (telem_req_o),
    .crc_err_o,
    .is_cmd_o   (is_command_o)
  );
endmodule

// File: rtl/pfr_rx_checker.sv
module pfr_rx_checker #(
  parameter int unsigned CLK_HZ = 48000000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        line_i,
  input logic [1:0]  rate_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [10:0] cmd_value_o,
  input logic        telem_req_o,
  input logic        crc_err_o,
  input logic        is_command_o
);
  int unsigned quiet_q;
  logic        line_prev_q;
  int unsigned nominal;

  assign nominal = CLK_HZ / pfr_pkg::rate_hz(rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q     <= 0;
      line_prev_q <= line_i;
    end else begin
      line_prev_q <= line_i;
      if (line_i != line_prev_q)   quiet_q <= 0;
      else if (quiet_q < 32'hFFFF) quiet_q <= quiet_q + 1;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(cmd_value_o) &&
      $stable(telem_req_o) && $stable(crc_err_o) && $stable(is_command_o))); // R11

  AST_DROP_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> !out_valid_o || $changed(cmd_value_o) ||
      $changed(telem_req_o) || $changed(crc_err_o) || $rose(out_valid_o) || quiet_q >= 3 * nominal); // R11

  AST_QUIET_BEFORE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> quiet_q >= 3 * nominal); // R7

  AST_CMD_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (is_command_o == (cmd_value_o < 11'd48))); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) AST_IDLE_IN_RESET: assert (!out_valid_o); // R12
  end
endmodule

bind pfr_rx pfr_rx_checker #(.CLK_HZ(CLK_HZ)) u_checker (
  .clk_i, .rst_ni, .line_i, .rate_i, .out_valid_o, .out_ready_i,
  .cmd_value_o, .telem_req_o, .crc_err_o, .is_command_o
);

// File: tb/pfr_rx_tb.sv
`timescale 1ns/1ps
module pfr_rx_tb;
  localparam int unsigned CLK_HZ = 12000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic [1:0]  rate = 2'd3;
  logic        bidir = 1'b0;
  logic        ready = 1'b1;
  logic        valid;
  logic [10:0] value;
  logic        telem, crc_err, is_cmd;

  int checks = 0;
  int fails  = 0;

  logic        got;
  int          got_k;
  logic [10:0] got_value;
  logic        got_telem, got_err, got_cmd;

  always #2 clk = ~clk;

  pfr_rx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .rate_i(rate), .bidir_i(bidir),
    .out_valid_o(valid), .out_ready_i(ready), .cmd_value_o(value),
    .telem_req_o(telem), .crc_err_o(crc_err), .is_command_o(is_cmd)
  );

  function automatic int period_of(input logic [1:0] r);
    return CLK_HZ / (150000 << r);
  endfunction

  function automatic logic [3:0] exp_crc(input logic [11:0] d, input logic inv);
    logic [11:0] x;
    x = d ^ (d >> 4) ^ (d >> 8);
    return inv ? ~x[3:0] : x[3:0];
  endfunction

  function automatic logic [15:0] mk(input logic [10:0] v, input logic t, input logic inv, input logic bad);
    logic [3:0] c;
    c = exp_crc({v, t}, inv) ^ {3'b000, bad};
    return {v, t, c};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [16:0] w, input int n);
    int p;
    int h;
    p = period_of(rate);
    for (int i = n - 1; i >= 0; i--) begin
      h = w[i] ? p - p / 3 : p / 3;
      line = ~bidir;
      repeat (h) @(negedge clk);
      line = bidir;
      repeat (p - h) @(negedge clk);
    end
  endtask

  task automatic wait_frame();
    int lim;
    lim = 4 * period_of(rate) + 40;
    got = 1'b0;
    got_k = 0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (valid && !got) begin
        got = 1'b1;
        got_k = k;
        got_value = value;
        got_telem = telem;
        got_err = crc_err;
        got_cmd = is_cmd;
      end
    end
  endtask

  task automatic set_mode(input logic [1:0] r, input logic b);
    @(negedge clk);
    rate  = r;
    bidir = b;
    line  = b;
    idle(4 * period_of(r) + 20);
  endtask

  task automatic frame_case(input logic [10:0] v, input logic t, input logic bad);
    logic [15:0] w;
    int p;
    int hl;
    p  = period_of(rate);
    w  = mk(v, t, bidir, bad);
    hl = w[0] ? p - p / 3 : p / 3;
    send({1'b0, w}, 16);
    wait_frame();
    check(got, "R1/R3 frame delivered", got, 1);
    if (got) begin
      check(got_value == v, "R2/R4 value", got_value, v);
      check(got_telem == t, "R4 telemetry flag", got_telem, t);
      check(got_err == bad, bidir ? "R6 inverted checksum" : "R5 checksum", got_err, bad);
      check(got_cmd == (v < 48), "R8 command class", got_cmd, v < 48);
      check(got_k == 2 * p + hl + 3, "R7 close latency", got_k, 2 * p + hl + 3);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] vals [8];
    vals = '{11'd0, 11'd1, 11'd47, 11'd48, 11'd49, 11'd1000, 11'd1365, 11'd2047};
    idle(3);
    check(valid == 1'b0, "R12 reset idle", valid, 0);
    rst_n = 1'b1;
    idle(2);
    check(valid == 1'b0, "R12 after reset", valid, 0);

    // R1 R2 R3 R4 R5 R6 R7 R8: sweep of rates, polarities, values, flags
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 2; b++) begin
        set_mode(2'(r), b[0]);
        for (int i = 0; i < 8; i++) frame_case(vals[i], i[0] ^ b[0], 1'b0);
      end
    end

    // R10: corrupted checksum still delivered, both polarities
    for (int b = 0; b < 2; b++) begin
      set_mode(2'd3, b[0]);
      frame_case(11'd300, 1'b1, 1'b1);
      frame_case(11'd20, 1'b0, 1'b1);
    end

    // R9: 15-bit and 17-bit frames are discarded
    set_mode(2'd3, 1'b0);
    begin
      logic [15:0] w;
      w = mk(11'd777, 1'b0, 1'b0, 1'b0);
      send({2'b00, w[15:1]}, 15);
      wait_frame();
      check(!got, "R9 short frame", got, 0);
      send({w, 1'b1}, 17);
      wait_frame();
      check(!got, "R9 long frame", got, 0);
      frame_case(11'd777, 1'b0, 1'b0);
    end

    // R11: back-pressure holds first frame, drops second
    ready = 1'b0;
    send({1'b0, mk(11'd100, 1'b1, 1'b0, 1'b0)}, 16);
    wait_frame();
    check(got && got_value == 11'd100, "R11 first frame held", got_value, 100);
    send({1'b0, mk(11'd200, 1'b0, 1'b0, 1'b0)}, 16);
    idle(4 * period_of(rate) + 20);
    check(valid == 1'b1, "R11 still valid under stall", valid, 1);
    check(value == 11'd100, "R11 fields stable", value, 100);
    check(telem == 1'b1, "R11 flag stable", telem, 1);
    ready = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R11 cleared after take", valid, 0);
    wait_frame();
    check(!got, "R11 second frame dropped", got, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule